// File: doc/BRIEF.md
# External Register Bus Bridge

This block connects a processor core to as many as eight user-defined registers that live outside the chip, such as a converter or a latch, over one shared 16-bit data bus. The core asks for a single read or write with a valid/ready handshake. The bridge then runs one bus cycle. It presents a latched 3-bit register address, a read/write direction strobe and an active-low data strobe. It drives the data pins only while writing. It stretches the cycle when the external wait input is high, and it can also add one internal wait state. When the cycle ends it returns a one-clock done pulse, which carries the read data on reads.

The request channel applies back-pressure. A request moves on a clock edge only when `req_valid` and `req_ready` are both high. `req_ready` stays low from the accepting edge until the cycle after the done pulse, and it stays low for as long as port mode is in force. The response channel has no ready signal, so the core must take `rsp_rdata` in the one cycle that `rsp_valid` is high. The core drives the port-mode, direction, output and wait-state controls as plain level signals.

In port mode the bus is handed over to general-purpose I/O. Each pin then has its own direction bit and output value. The pin levels are returned to the core through a two-flop synchronizer.

Top module: `ext_reg_bridge`

## Requirements
- R1: While `rst_n` is low, `ext_ds_n` is 1, `ext_rnw` is 1, `bus_oe` is all zeros and `rsp_valid` is 0. After reset, `req_ready` is 1 when port mode is off.
- R2: Outside port mode, `bus_oe` is all ones only during a write cycle, from the accepting edge until the edge after the done pulse, and all zeros otherwise. `ext_rnw` is 0 exactly while the bus is driven and 1 during reads and idle.
- R3: `ext_addr` takes `req_index` on the accepting edge and holds it through the done cycle. On writes, `bus_dout` holds `req_wdata` over the same span.
- R4: `ext_ds_n` falls on the accepting edge and stays low for at least one clock. It rises on the edge that completes the cycle.
- R5: On a read, `rsp_rdata` carries the value `bus_din` had at the completing edge, the one on which `ext_ds_n` rises.
- R6: `rsp_valid` is high for exactly the one clock that follows the rise of `ext_ds_n`. `req_ready` is 0 from the accepting edge until that done cycle has ended.
- R7: `ext_wait` (active high) is sampled on each rising edge while the strobe is low and the internal wait is spent. Each high sample lengthens the strobe by one clock. The cycle completes on the first such edge where it is low.
- R8: If `cfg_wait_en` is 1 when a request is accepted, the first edge after acceptance is always a wait edge and `ext_wait` is ignored on it. The strobe then lasts 2 clocks plus one clock per later high `ext_wait` sample.
- R9: With port mode in force, `req_ready` is 0 and `req_valid` starts no cycle (`ext_ds_n` stays 1). `bus_oe` equals `port_dir` and `bus_dout` equals `port_out`, each one clock after it is applied.
- R10: `port_in` equals `bus_din` two clocks after `bus_din` changes, and it still holds the earlier value after only one clock.
- R11: A change on `cfg_port_mode` during a bus cycle does not disturb that cycle. Port mode takes effect on the second edge after the done cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 3 | External register index |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Done pulse, one clock |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid |
| cfg_wait_en | input | 1 | Add one internal wait state per cycle |
| cfg_port_mode | input | 1 | Hand data pins to general-purpose I/O |
| port_dir | input | 16 | Per-pin output enable in port mode |
| port_out | input | 16 | Per-pin output value in port mode |
| port_in | output | 16 | Synchronized pin levels |
| ext_addr | output | 3 | Latched external register address |
| ext_rnw | output | 1 | Direction strobe, 0 while bridge drives |
| ext_ds_n | output | 1 | Data strobe, active low |
| ext_wait | input | 1 | External wait request, active high |
| bus_din | input | 16 | Data pin input levels |
| bus_dout | output | 16 | Data pin output values |
| bus_oe | output | 16 | Data pin output enables |

## Verification
The assertions assume that `ext_wait` and `bus_din` are stable around each rising edge. They also assume the core holds a request steady while `req_valid` is high and takes each response in its single cycle. The bench changes every input only on falling edges. It raises `req_valid` for exactly one accepting edge, and it samples `rsp_rdata` in the done cycle. It sets `cfg_port_mode` mid-cycle only in the scenario that targets that case.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE   = 2'd0,
    BUS_STROBE = 2'd1,
    BUS_DONE   = 2'd2
  } bus_state_t;
endpackage

// File: rtl/ext_bus_fsm.sv
module ext_bus_fsm
  import ext_bus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_index,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              cfg_wait_en,
  input  logic              cfg_port_mode,
  input  logic              ext_wait,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              ext_rnw,
  output logic              ext_ds_n,
  output logic              drive_en,
  output logic [DATA_W-1:0] wdata_q,
  output logic              port_active
);
  bus_state_t st_q;
  logic       iw_q;
  logic       accept;

  assign req_ready = (st_q == BUS_IDLE) && !port_active && !cfg_port_mode;
  assign accept    = req_valid && req_ready;
  assign rsp_valid = (st_q == BUS_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= BUS_IDLE;
      iw_q        <= 1'b0;
      ext_addr    <= '0;
      wdata_q     <= '0;
      ext_rnw     <= 1'b1;
      ext_ds_n    <= 1'b1;
      drive_en    <= 1'b0;
      rsp_rdata   <= '0;
      port_active <= 1'b0;
    end else begin
      unique case (st_q)
        BUS_IDLE: begin
          port_active <= cfg_port_mode;
          if (accept) begin
            ext_addr <= req_index;
            if (req_write) wdata_q <= req_wdata;
            ext_rnw  <= !req_write;
            drive_en <= req_write;
            ext_ds_n <= 1'b0;
            iw_q     <= cfg_wait_en;
            st_q     <= BUS_STROBE;
          end
        end
        BUS_STROBE: begin
          if (iw_q) begin
            iw_q <= 1'b0;
          end else if (!ext_wait) begin
            ext_ds_n <= 1'b1;
            if (ext_rnw) rsp_rdata <= bus_din;
            st_q <= BUS_DONE;
          end
        end
        BUS_DONE: begin
          drive_en <= 1'b0;
          ext_rnw  <= 1'b1;
          st_q     <= BUS_IDLE;
        end
        default: st_q <= BUS_IDLE;
      endcase
    end
  end

  // R3: address held steady across a running cycle
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != BUS_IDLE && $past(st_q) != BUS_IDLE) |-> $stable(ext_addr));

  // R6: done lasts a single clock
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R6: strobe rise is followed by done in that same cycle
  a_r6_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_ds_n) |-> rsp_valid);

  // R7: a high wait sample keeps the strobe low
  a_r7_wait_extends: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_ds_n && !iw_q && ext_wait) |=> !ext_ds_n);

  // R8: internal wait edge never completes the cycle
  a_r8_internal_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_ds_n && iw_q) |=> !ext_ds_n);

  // R6: no acceptance while a strobe is active
  a_r6_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ext_ds_n);
endmodule

// File: rtl/ext_port_gpio.sv
module ext_port_gpio #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] port_dir,
  input  logic [DATA_W-1:0] port_out,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] dir_q,
  output logic [DATA_W-1:0] out_q,
  output logic [DATA_W-1:0] port_in
);
  logic [DATA_W-1:0] sync_q [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      dir_q <= port_dir;
      out_q <= port_out;
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= '0;
        else if (s == 0) sync_q[s] <= pin_in;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign port_in = sync_q[SYNC_STAGES-1];

  // R9: registered direction follows the core one clock later
  a_r9_dir_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dir_q == $past(port_dir)));
endmodule

// File: rtl/ext_pin_mux.sv
module ext_pin_mux #(
  parameter int DATA_W = 16
) (
  input  logic              port_active,
  input  logic              drive_en,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic [DATA_W-1:0] dir_q,
  input  logic [DATA_W-1:0] out_q,
  output logic [DATA_W-1:0] bus_dout,
  output logic [DATA_W-1:0] bus_oe
);
  always_comb begin
    if (port_active) begin
      bus_oe   = dir_q;
      bus_dout = out_q;
    end else begin
      bus_oe   = {DATA_W{drive_en}};
      bus_dout = wdata_q;
    end
  end
endmodule

// File: rtl/ext_reg_bridge.sv
module ext_reg_bridge #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_index,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              cfg_wait_en,
  input  logic              cfg_port_mode,
  input  logic [DATA_W-1:0] port_dir,
  input  logic [DATA_W-1:0] port_out,
  output logic [DATA_W-1:0] port_in,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              ext_rnw,
  output logic              ext_ds_n,
  input  logic              ext_wait,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic [DATA_W-1:0] bus_oe
);
  logic              drive_en;
  logic              port_active;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] dir_q;
  logic [DATA_W-1:0] out_q;

  ext_bus_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_index(req_index), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_wait_en(cfg_wait_en), .cfg_port_mode(cfg_port_mode),
    .ext_wait(ext_wait), .bus_din(bus_din),
    .ext_addr(ext_addr), .ext_rnw(ext_rnw), .ext_ds_n(ext_ds_n),
    .drive_en(drive_en), .wdata_q(wdata_q), .port_active(port_active)
  );

  ext_port_gpio #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_gpio (
    .clk(clk), .rst_n(rst_n),
    .port_dir(port_dir), .port_out(port_out), .pin_in(bus_din),
    .dir_q(dir_q), .out_q(out_q), .port_in(port_in)
  );

  ext_pin_mux #(.DATA_W(DATA_W)) u_mux (
    .port_active(port_active), .drive_en(drive_en), .wdata_q(wdata_q),
    .dir_q(dir_q), .out_q(out_q), .bus_dout(bus_dout), .bus_oe(bus_oe)
  );

  // R2: bus driven in bus mode only with direction strobe low
  a_r2_drive_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_active && (|bus_oe)) |-> !ext_rnw);

  // R9: port mode never strobes
  a_r9_port_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    port_active |-> ext_ds_n);
endmodule

// File: tb/ext_reg_bridge_bench.sv
module ext_reg_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, cfg_wait_en, cfg_port_mode, ext_wait;
  logic [2:0]  req_index;
  logic [15:0] req_wdata, port_dir, port_out, bus_din;
  logic        req_ready, rsp_valid, ext_rnw, ext_ds_n;
  logic [15:0] rsp_rdata, port_in, bus_dout, bus_oe;
  logic [2:0]  ext_addr;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  ext_reg_bridge u_ext_reg_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_index(req_index), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cfg_wait_en(cfg_wait_en),
    .cfg_port_mode(cfg_port_mode), .port_dir(port_dir), .port_out(port_out),
    .port_in(port_in), .ext_addr(ext_addr), .ext_rnw(ext_rnw),
    .ext_ds_n(ext_ds_n), .ext_wait(ext_wait), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_oe(bus_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_xfer(input logic wr, input logic [2:0] idx, input logic [15:0] wd,
                         input logic iw, input int ew, input logic [15:0] rd);
    int low;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_index = idx; req_wdata = wd;
    cfg_wait_en = iw; ext_wait = 1'b0; bus_din = ~rd;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = 16'h0; req_index = ~idx;
    low = 0;
    while (ext_ds_n == 1'b0 && low < 50) begin
      low++;
      chk("R3 addr", ext_addr, idx);
      chk("R2 rnw", ext_rnw, !wr);
      chk("R2 oe", bus_oe, wr ? 16'hFFFF : 16'h0);
      if (wr) chk("R3 wdata", bus_dout, wd);
      chk("R6 ready low", req_ready, 0);
      ext_wait = (low <= int'(iw) + ew);
      bus_din  = (low == int'(iw) + ew + 1) ? rd : ~rd;
      @(negedge clk);
    end
    ext_wait = 1'b0;
    chk("R4 R7 R8 strobe clocks", low, 1 + int'(iw) + ew);
    chk("R6 done", rsp_valid, 1);
    chk("R3 addr in done", ext_addr, idx);
    if (!wr) chk("R5 rdata", rsp_rdata, rd);
    else chk("R2 oe in done", bus_oe, 16'hFFFF);
    @(negedge clk);
    chk("R6 done one clock", rsp_valid, 0);
    chk("R2 released", bus_oe, 0);
    chk("R2 rnw idle", ext_rnw, 1);
    chk("R6 ready again", req_ready, 1);
    cfg_wait_en = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_index = 0; req_wdata = 0;
    cfg_wait_en = 0; cfg_port_mode = 0; ext_wait = 0; bus_din = 0;
    port_dir = 0; port_out = 0;
    repeat (3) @(negedge clk);
    chk("R1 ds_n", ext_ds_n, 1);
    chk("R1 rnw", ext_rnw, 1);
    chk("R1 oe", bus_oe, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", req_ready, 1);
  endtask

  task automatic t_port_mode;
    @(negedge clk);
    cfg_port_mode = 1; port_dir = 16'h00FF; port_out = 16'hA5C3; req_valid = 1;
    req_write = 1;
    @(negedge clk);
    chk("R9 ready low", req_ready, 0);
    chk("R9 oe", bus_oe, 16'h00FF);
    chk("R9 dout", bus_dout, 16'hA5C3);
    port_out = 16'h5A3C;
    @(negedge clk);
    chk("R9 no strobe", ext_ds_n, 1);
    chk("R9 dout follow", bus_dout, 16'h5A3C);
    req_valid = 0; bus_din = 16'h0F0F;
    repeat (3) @(negedge clk);
    bus_din = 16'h1234;
    @(negedge clk);
    chk("R10 one clock", port_in, 16'h0F0F);
    @(negedge clk);
    chk("R10 two clocks", port_in, 16'h1234);
    cfg_port_mode = 0;
    @(negedge clk);
    chk("R9 ready after exit", req_ready, 1);
  endtask

  task automatic t_mode_mid;
    int n;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_index = 3'd6; req_wdata = 16'hC0DE;
    ext_wait = 1; port_dir = 16'h00F0;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    cfg_port_mode = 1;
    @(negedge clk);
    chk("R11 strobe held", ext_ds_n, 0);
    chk("R11 oe held", bus_oe, 16'hFFFF);
    chk("R11 dout held", bus_dout, 16'hC0DE);
    ext_wait = 0;
    n = 0;
    while (!rsp_valid && n < 20) begin @(negedge clk); n++; end
    chk("R11 done", rsp_valid, 1);
    @(negedge clk);
    chk("R11 not yet", bus_oe, 0);
    @(negedge clk);
    chk("R11 port now", bus_oe, 16'h00F0);
    cfg_port_mode = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    do_xfer(1, 3'd5, 16'hBEEF, 0, 0, 16'h0);
    do_xfer(0, 3'd2, 16'h0, 0, 0, 16'h1234);
    do_xfer(1, 3'd7, 16'h55AA, 0, 3, 16'h0);
    do_xfer(0, 3'd0, 16'h0, 1, 0, 16'h8001);
    do_xfer(1, 3'd1, 16'h7E7E, 1, 2, 16'h0);
    do_xfer(0, 3'd4, 16'h0, 1, 1, 16'hFACE);
    t_port_mode();
    t_mode_mid();
    do_xfer(0, 3'd3, 16'h0, 0, 1, 16'h4321);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule